// File: doc/BRIEF.md
# Per-Window Endian Byte-Lane Mapper

This block sits on the 32-bit data path between an internal system bus and a PCI bus. It rearranges the byte lanes of each transfer and its byte enables. The choice depends on three things: the core's global endian mode, the direction of the transfer, and a byte-swap flag that belongs to the access window the transfer hit. Address decoding happens elsewhere, so the window index arrives as an input. Outbound windows (internal bus to PCI, called initiator windows) and inbound windows (PCI to internal bus, called target windows) each keep their own set of swap flags. These flags sit in a small register file that is written through a one-cycle write port.

On the internal bus, byte address k of a word sits on lane k in little-endian mode and on lane 3-k in big-endian mode. On PCI, byte address k always sits on lane k. Lane j carries bits [8j+7:8j]. With no swap, the mapping keeps byte addresses: each byte keeps its byte address across the bridge. In big-endian mode this reverses the lanes, and a little-endian PCI device then sees multi-byte values in reversed byte order. A set swap flag in big-endian mode passes the lanes straight through instead, so a 32-bit value keeps its bit order. In little-endian mode the swap flags have no effect.

The block also trims every transfer to the bytes its size and address cover. Lanes outside that footprint, and lanes whose byte enable is low, leave with the enable cleared and the data zeroed. The result is registered and appears one clock after the transfer is presented.

Top module: `endian_lane_mapper`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `data_out` and `be_out` are zero. Reset clears every swap flag, so after reset every window maps as unswapped.
- R2: With `be_mode`=0 (little-endian), output lane j carries input lane j in both directions, whatever the swap flags hold.
- R3: With `be_mode`=1 and the selected swap flag clear, output lane j carries input lane 3-j. Example: a 16-bit initiator transfer at address 0 with `data_in`=32'hAABB0000 and `be_in`=4'b1100 yields `data_out`=32'h0000BBAA and `be_out`=4'b0011.
- R4: With `be_mode`=1 and the selected swap flag set, output lane j carries input lane j.
- R5: The swap flag is chosen by `xfer_tgt` (0 = initiator set, 1 = target set) and `win_idx`. A write with `cfg_we`=1 stores `cfg_swap` into entry `cfg_idx` of the set chosen by `cfg_tgt` and changes no other entry.
- R6: Byte enables follow the same lane permutation as the data, so an output lane's enable is the enable of the input lane it carries.
- R7: `size` encodes the footprint as 0 = 1 byte, 1 = 2 bytes aligned down to an even address, and 2 or 3 = all 4 bytes. An input lane is counted only if it lies in the footprint of `addr` and its `be_in` bit is set. On initiator transfers, input lane j holds byte address j in little-endian mode and 3-j in big-endian mode. On target transfers, input lane j always holds byte address j. An output lane whose enable is low carries zero data.
- R8: A transfer presented in cycle n appears on the outputs after the clock edge that ends cycle n. If a swap-flag write happens in the same cycle, the transfer still uses the old flag value, and the new value applies from cycle n+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| be_mode | input | 1 | 1 = core runs big-endian |
| cfg_we | input | 1 | Swap-flag write strobe |
| cfg_tgt | input | 1 | Write selects target set (1) or initiator set (0) |
| cfg_idx | input | IDX_W (2) | Window entry to write |
| cfg_swap | input | 1 | Swap-flag value to store |
| xfer_tgt | input | 1 | Transfer direction: 1 = PCI to internal bus |
| win_idx | input | IDX_W (2) | Window the transfer hit |
| size | input | 2 | Access size code |
| addr | input | 2 | Byte address within the word |
| data_in | input | DATA_W (32) | Transfer data, source-side lanes |
| be_in | input | LANES (4) | Source-side byte enables |
| data_out | output | DATA_W (32) | Remapped data, registered |
| be_out | output | LANES (4) | Remapped byte enables, registered |

## Verification
The bench builds the block with its defaults: DATA_W=32 and NUM_WIN=4. This makes the full cross of both directions, every window, both modes, both swap values, every size code and every byte offset small enough to sweep exhaustively, and the bench checks each case against its own byte-address model. Seeded random traffic then mixes in swap-flag writes that land in the same cycle as transfers, which exercises the rule that a write applies from the next cycle on. Random byte-enable patterns make footprint trimming and enable permutation interact.

// File: rtl/elm_pkg.sv
package elm_pkg;
  localparam int BYTE_W = 8;
  localparam int SIZE_W = 2;
  typedef enum logic {
    DIR_INIT = 1'b0,
    DIR_TGT  = 1'b1
  } dir_e;
endpackage

// File: rtl/elm_swap_regs.sv
module elm_swap_regs #(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             wr_tgt,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_val,
  input  logic             rd_tgt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_swap
);
  logic [NUM_WIN-1:0] init_q;
  logic [NUM_WIN-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= '0;
      tgt_q  <= '0;
    end else if (we) begin
      if (wr_tgt == elm_pkg::DIR_TGT) tgt_q[wr_idx] <= wr_val;
      else                            init_q[wr_idx] <= wr_val;
    end
  end

  assign rd_swap = (rd_tgt == elm_pkg::DIR_TGT) ? tgt_q[rd_idx] : init_q[rd_idx];

  // R5: a write lands in the addressed entry
  a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> ((($past(wr_tgt) ? tgt_q[$past(wr_idx)] : init_q[$past(wr_idx)])) == $past(wr_val)));
  // R5: the other set is left alone
  a_r5_init_write_spares_tgt: assert property (@(posedge clk) disable iff (rst)
    (we && !wr_tgt) |=> $stable(tgt_q));
  a_r5_tgt_write_spares_init: assert property (@(posedge clk) disable iff (rst)
    (we && wr_tgt) |=> $stable(init_q));
endmodule

// File: rtl/elm_lane_mask.sv
module elm_lane_mask #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 2
) (
  input  logic                      be_mode,
  input  logic                      xfer_tgt,
  input  logic [elm_pkg::SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]          be_in,
  output logic [LANES-1:0]          lane_en
);
  logic big_src;
  assign big_src = be_mode && (xfer_tgt == elm_pkg::DIR_INIT);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [ADDR_W-1:0] byte_addr;
    logic              in_foot;
    assign byte_addr = big_src ? ADDR_W'(LANES - 1 - j) : ADDR_W'(j);
    assign in_foot   = (32'(size) >= 32'(ADDR_W)) ||
                       ((byte_addr >> size) == (addr >> size));
    assign lane_en[j] = be_in[j] && in_foot;
  end
endmodule

// File: rtl/elm_lane_perm.sv
module elm_lane_perm #(
  parameter int LANES = 4
) (
  input  logic                             rev,
  input  logic [LANES*elm_pkg::BYTE_W-1:0] data_in,
  input  logic [LANES-1:0]                 en_in,
  output logic [LANES*elm_pkg::BYTE_W-1:0] data_out,
  output logic [LANES-1:0]                 en_out
);
  localparam int BW = elm_pkg::BYTE_W;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [BW-1:0] pick;
    assign en_out[j] = rev ? en_in[LANES-1-j] : en_in[j];
    assign pick      = rev ? data_in[(LANES-1-j)*BW +: BW] : data_in[j*BW +: BW];
    assign data_out[j*BW +: BW] = en_out[j] ? pick : '0;
  end
endmodule

// File: rtl/endian_lane_mapper.sv
module endian_lane_mapper #(
  parameter int DATA_W  = 32,
  parameter int NUM_WIN = 4,
  localparam int LANES  = DATA_W / elm_pkg::BYTE_W,
  localparam int ADDR_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int IDX_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       be_mode,
  input  logic                       cfg_we,
  input  logic                       cfg_tgt,
  input  logic [IDX_W-1:0]           cfg_idx,
  input  logic                       cfg_swap,
  input  logic                       xfer_tgt,
  input  logic [IDX_W-1:0]           win_idx,
  input  logic [elm_pkg::SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          data_in,
  input  logic [LANES-1:0]           be_in,
  output logic [DATA_W-1:0]          data_out,
  output logic [LANES-1:0]           be_out
);
  localparam int BW = elm_pkg::BYTE_W;

  logic              win_swap;
  logic              rev;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] perm_data;
  logic [LANES-1:0]  perm_en;

  elm_swap_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) swap_regs_i (
    .clk(clk), .rst(rst), .we(cfg_we), .wr_tgt(cfg_tgt), .wr_idx(cfg_idx),
    .wr_val(cfg_swap), .rd_tgt(xfer_tgt), .rd_idx(win_idx), .rd_swap(win_swap)
  );

  elm_lane_mask #(.LANES(LANES), .ADDR_W(ADDR_W)) lane_mask_i (
    .be_mode(be_mode), .xfer_tgt(xfer_tgt), .size(size), .addr(addr),
    .be_in(be_in), .lane_en(lane_en)
  );

  // Swap only matters for a big-endian core; otherwise keep addresses.
  assign rev = be_mode && !win_swap;

  elm_lane_perm #(.LANES(LANES)) lane_perm_i (
    .rev(rev), .data_in(data_in), .en_in(lane_en),
    .data_out(perm_data), .en_out(perm_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      be_out   <= '0;
    end else begin
      data_out <= perm_data;
      be_out   <= perm_en;
    end
  end

  // R1: outputs clear coming out of reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (data_out == '0 && be_out == '0));
  // R6: permutation keeps the number of enabled lanes
  a_r6_enable_count: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(be_out) == $countones($past(lane_en))));
  // R2: little-endian passes enables straight through
  a_r2_le_identity: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(be_mode)) |-> (be_out == $past(lane_en)));

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    // R7: disabled lanes carry zero data
    a_r7_idle_lane_zero: assert property (@(posedge clk) disable iff (rst)
      !be_out[j] |-> (data_out[j*BW +: BW] == '0));
  end
endmodule

// File: tb/endian_lane_mapper_tb_top.sv
module endian_lane_mapper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        be_mode = 1'b0;
  logic        cfg_we = 1'b0, cfg_tgt = 1'b0, cfg_swap = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        xfer_tgt = 1'b0;
  logic [1:0]  win_idx = '0, size = '0, addr = '0;
  logic [31:0] data_in = '0;
  logic [3:0]  be_in = '0;
  logic [31:0] data_out;
  logic [3:0]  be_out;

  int errors = 0;
  int checks = 0;
  bit model_sw [2][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  endian_lane_mapper dut_i (
    .clk(clk), .rst(rst), .be_mode(be_mode), .cfg_we(cfg_we), .cfg_tgt(cfg_tgt),
    .cfg_idx(cfg_idx), .cfg_swap(cfg_swap), .xfer_tgt(xfer_tgt), .win_idx(win_idx),
    .size(size), .addr(addr), .data_in(data_in), .be_in(be_in),
    .data_out(data_out), .be_out(be_out)
  );

  function automatic logic [35:0] ref_out(bit bem, bit tgt, bit sw, logic [1:0] sz,
                                          logic [1:0] ad, logic [31:0] d, logic [3:0] b);
    logic [31:0] od = '0;
    logic [3:0]  ob = '0;
    bit rev = bem && !sw;
    for (int j = 0; j < 4; j++) begin
      int s = rev ? 3 - j : j;
      int k = (bem && !tgt) ? 3 - s : s;
      bit inf = (sz >= 2) || ((k >> int'(sz)) == (int'(ad) >> int'(sz)));
      if (b[s] && inf) begin
        ob[j] = 1'b1;
        od[8*j +: 8] = d[8*s +: 8];
      end
    end
    return {od, ob};
  endfunction

  function automatic string mode_tag(bit bem, bit sw);
    if (!bem) return "R2";
    if (!sw)  return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, logic [31:0] ed, logic [3:0] eb);
    checks++;
    if (data_out !== ed || be_out !== eb) begin
      errors++;
      $display("FAIL %s: data=%h be=%b expected data=%h be=%b", tag, data_out, be_out, ed, eb);
    end
  endtask

  // One cycle: optional swap write plus a transfer; the transfer uses the old flags (R8).
  task automatic step(string tag, bit we, bit ct, logic [1:0] ci, bit cs,
                      bit bem, bit tgt, logic [1:0] wi, logic [1:0] sz,
                      logic [1:0] ad, logic [31:0] d, logic [3:0] b);
    logic [35:0] e;
    string t;
    @(negedge clk);
    cfg_we = we; cfg_tgt = ct; cfg_idx = ci; cfg_swap = cs;
    be_mode = bem; xfer_tgt = tgt; win_idx = wi; size = sz; addr = ad;
    data_in = d; be_in = b;
    e = ref_out(bem, tgt, model_sw[tgt][wi], sz, ad, d, b);
    t = (tag == "") ? mode_tag(bem, model_sw[tgt][wi]) : tag;
    if (we) model_sw[ct][ci] = cs;
    @(negedge clk);
    cfg_we = 1'b0;
    check(t, e[35:4], e[3:0]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: data=%h be=%b expected data=%h be=%b", data_out, be_out, 32'h0, 4'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int t = 0; t < 2; t++) for (int w = 0; w < 4; w++) model_sw[t][w] = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 32'h0, 4'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 32'h0, 4'h0);

    // R1: every swap flag clear after reset -> big-endian reverses
    for (int w = 0; w < 4; w++) begin
      step("R1", 0, 0, 0, 0, 1, 0, 2'(w), 2, 0, 32'h11223344, 4'hF);
      step("R1", 0, 0, 0, 0, 1, 1, 2'(w), 2, 0, 32'h55667788, 4'hF);
    end
    // R3: halfword at address 0, big-endian, no swap
    step("R3", 0, 0, 0, 0, 1, 0, 0, 1, 0, 32'hAABB0000, 4'b1100);
    // R4: swap on initiator window 2 makes a word pass straight
    step("R5", 1, 0, 2, 1, 0, 0, 0, 2, 0, 32'h0, 4'h0);
    step("R4", 0, 0, 0, 0, 1, 0, 2, 2, 0, 32'hDEADBEEF, 4'hF);
    // R5: target window 2 still unswapped
    step("R5", 0, 0, 0, 0, 1, 1, 2, 2, 0, 32'hDEADBEEF, 4'hF);
    // R8: write in the same cycle as a transfer on that window
    step("R8", 1, 0, 1, 1, 1, 0, 1, 2, 0, 32'h01020304, 4'hF);
    step("R8", 0, 0, 0, 0, 1, 0, 1, 2, 0, 32'h01020304, 4'hF);
    // R6: partial enable follows the lanes
    step("R6", 0, 0, 0, 0, 1, 0, 0, 2, 0, 32'h00CC0000, 4'b0100);
    // R7: byte at address 1, little-endian, all enables offered
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hFFEEDDCC, 4'hF);
    // R2: little-endian ignores a set swap flag
    step("R2", 0, 0, 0, 0, 0, 0, 2, 2, 0, 32'hCAFEF00D, 4'hF);

    // Exhaustive sweep across direction, window, swap, mode, size, offset
    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 4; w++)
        for (int s = 0; s < 2; s++) begin
          step("R5", 1, t[0], 2'(w), s[0], 0, 0, 0, 2, 0, 32'h0, 4'h0);
          for (int m = 0; m < 2; m++)
            for (int z = 0; z < 4; z++)
              for (int a = 0; a < 4; a++)
                step("", 0, 0, 0, 0, m[0], t[0], 2'(w), 2'(z), 2'(a),
                     32'h8A9BACBD ^ (32'(w) << 4), 4'hF);
        end

    // Random traffic with interleaved swap writes and random enables (R6 R7 R8)
    for (int i = 0; i < 3000; i++) begin
      step("", ($urandom % 4) == 0, 1'($urandom), 2'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
           $urandom, 4'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule